// File: doc/BRIEF.md
# Level-Match GPIO Controller

This block manages 32 general-purpose pins behind a small word-addressed register port. Each pin is either kept as GPIO or handed to an alternate on-chip function. As GPIO a pin is an input or an output, and an output drives the value held in the data register. Incoming pad values are resynchronised through two flip-flops. The synchronised value is what the data register reads back, what the alternate functions receive, and what the interrupt logic compares.

Each pin has a programmable level bit. When the synchronised pin value equals that level, the pin's status bit is latched and stays set until software clears it. Software clears a bit by writing 0 to it. A per-pin enable mask steers each status bit to one of two outputs: the non-maskable interrupt output or the ordinary interrupt output. A pin in alternate-function mode never sets its status bit.

The register file has six words at byte offsets 0x00 (function select, 1 = alternate), 0x04 (direction, 1 = output), 0x08 (data), 0x0C (level), 0x10 (status) and 0x14 (NMI enable). Register writes take effect on the clock edge. Register reads are combinational from the address. The block has no state machine. Its only sequencing is the two-stage synchroniser followed by the status register.

Top module: `gpio_lvlirq`

## Requirements
- R1: After reset, the function, direction, data, status and NMI-enable registers read 0, the level register reads all ones, and `irq` and `nmi` are 0.
- R2: For a pin whose function bit is 0, `pad_out` equals its data-register bit and `pad_oe` equals its direction bit.
- R3: For a pin whose function bit is 1, `pad_out` follows `alt_out` and `pad_oe` follows `alt_oe` for that pin.
- R4: Reading offset 0x08, and the `alt_in` output, return `pad_in` delayed by two clock edges. After one edge the old value still reads back.
- R5: On the clock edge after a GPIO pin's synchronised value equals its level bit, the status bit (offset 0x10) is set. The bit stays set after the pin stops matching.
- R6: A write to offset 0x10 clears each status bit whose write-data bit is 0, and a write-data bit of 1 leaves the status bit unchanged. If the pin still matches in that cycle, the bit stays set.
- R7: A pin whose function bit is 1 never sets its status bit, whatever its level.
- R8: `nmi` is 1 exactly when some status bit is set whose NMI-enable bit (offset 0x14) is 1. `irq` is 1 exactly when some status bit is set whose NMI-enable bit is 0.
- R9: The function, direction, level and NMI-enable registers read back what was written. Reads of any address other than the six offsets return 0, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Byte address of the register |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad input values |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Pad output enable |
| alt_out | input | 32 | Output values from the alternate functions |
| alt_oe | input | 32 | Output enables from the alternate functions |
| alt_in | output | 32 | Synchronised pad values for the alternate functions |
| irq | output | 1 | Ordinary interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The synchroniser latency assertion assumes that `pad_in` stays defined and that the checked history lies wholly after reset release. The bench meets this by holding every pad input at a known value from time zero. The status assertions assume that a clear happens only through a write strobe at offset 0x10. The bench changes pads and register contents only on falling edges and waits at least three edges after a pad change before judging status or interrupts, so no check depends on a value that is still settling.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
    localparam int ADDR_W = 5;
    localparam int NPINS  = 32;

    localparam logic [ADDR_W-1:0] OFS_FUNC  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_LVL   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_NMIEN = 5'h14;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

    // R4: two-edge latency once two post-reset edges have passed
    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_lvl_status.sv
module gpio_lvl_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_s,
    input  logic [N-1:0] level,
    input  logic [N-1:0] gpio_en,
    input  logic         clr_en,
    input  logic [N-1:0] clr_keep,
    output logic [N-1:0] stat
);
    logic [N-1:0] hit;
    logic [N-1:0] stat_q;

    always_comb begin
        hit = gpio_en & ~(pin_s ^ level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (clr_en) begin
            stat_q <= (stat_q & clr_keep) | hit;
        end else begin
            stat_q <= stat_q | hit;
        end
    end

    assign stat = stat_q;

    // R5: without a clear strobe no status bit falls
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((stat & $past(stat)) == $past(stat)));

    // R6: a matching pin is set after the edge even under a clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));

    // R7: a pin not in GPIO mode never gains a status bit
    assert_alt_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(gpio_en)) == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int N = 32
) (
    input  logic [N-1:0] func_sel,
    input  logic [N-1:0] gp_out,
    input  logic [N-1:0] gp_oe,
    input  logic [N-1:0] alt_out,
    input  logic [N-1:0] alt_oe,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pad_out[i] = func_sel[i] ? alt_out[i] : gp_out[i];
        assign pad_oe[i]  = func_sel[i] ? alt_oe[i]  : gp_oe[i];
    end
endmodule

// File: rtl/gpio_lvlirq.sv
module gpio_lvlirq #(
    parameter logic [gpl_pkg::NPINS-1:0] LVL_RST = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [gpl_pkg::ADDR_W-1:0]  reg_addr,
    input  logic                        reg_we,
    input  logic [gpl_pkg::NPINS-1:0]   reg_wdata,
    output logic [gpl_pkg::NPINS-1:0]   reg_rdata,
    input  logic [gpl_pkg::NPINS-1:0]   pad_in,
    output logic [gpl_pkg::NPINS-1:0]   pad_out,
    output logic [gpl_pkg::NPINS-1:0]   pad_oe,
    input  logic [gpl_pkg::NPINS-1:0]   alt_out,
    input  logic [gpl_pkg::NPINS-1:0]   alt_oe,
    output logic [gpl_pkg::NPINS-1:0]   alt_in,
    output logic                        irq,
    output logic                        nmi
);
    import gpl_pkg::*;
    localparam int N = NPINS;

    logic [N-1:0] func_q, dir_q, data_q, lvl_q, nmien_q;
    logic [N-1:0] pin_s, stat;
    logic         stat_wr;

    assign stat_wr = reg_we && (reg_addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q  <= '0;
            dir_q   <= '0;
            data_q  <= '0;
            lvl_q   <= LVL_RST;
            nmien_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_FUNC:  func_q  <= reg_wdata;
                OFS_DIR:   dir_q   <= reg_wdata;
                OFS_DATA:  data_q  <= reg_wdata;
                OFS_LVL:   lvl_q   <= reg_wdata;
                OFS_NMIEN: nmien_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_FUNC:  reg_rdata = func_q;
            OFS_DIR:   reg_rdata = dir_q;
            OFS_DATA:  reg_rdata = pin_s;
            OFS_LVL:   reg_rdata = lvl_q;
            OFS_STAT:  reg_rdata = stat;
            OFS_NMIEN: reg_rdata = nmien_q;
            default:   reg_rdata = '0;
        endcase
    end

    gpio_sync2 #(.W(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    gpio_lvl_status #(.N(N)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .level    (lvl_q),
        .gpio_en  (~func_q),
        .clr_en   (stat_wr),
        .clr_keep (reg_wdata),
        .stat     (stat)
    );

    gpio_pad_mux #(.N(N)) u_mux (
        .func_sel (func_q),
        .gp_out   (data_q),
        .gp_oe    (dir_q),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    assign alt_in = pin_s;
    assign nmi    = |(stat & nmien_q);
    assign irq    = |(stat & ~nmien_q);

    // R8: with no status bit set, neither interrupt output is raised
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> (!irq && !nmi));

    // R9: a write to an unmapped address leaves the function select unchanged
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr > OFS_NMIEN) |=> $stable(func_q));
endmodule

// File: tb/gpio_lvlirq_test.sv
module gpio_lvlirq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic [31:0] alt_out = '0;
    logic [31:0] alt_oe = '0;
    logic [31:0] alt_in;
    logic        irq, nmi;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_lvlirq uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .alt_in(alt_in), .irq(irq), .nmi(nmi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 func", v, 32'h0);
        rd(5'h04, v); chk("R1 dir", v, 32'h0);
        rd(5'h08, v); chk("R1 data", v, 32'h0);
        rd(5'h0C, v); chk("R1 level", v, 32'hFFFF_FFFF);
        rd(5'h10, v); chk("R1 status", v, 32'h0);
        rd(5'h14, v); chk("R1 nmien", v, 32'h0);
        chk("R1 irq/nmi", {30'd0, irq, nmi}, 32'h0);
    endtask

    task automatic t_gpio_out;
        wr(5'h04, 32'h0000_FFFF);
        wr(5'h08, 32'hA5A5_1234);
        #1;
        chk("R2 pad_out", pad_out, 32'hA5A5_1234);
        chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    endtask

    task automatic t_alt_mux;
        alt_out = 32'h1234_5678;
        alt_oe  = 32'hF0F0_F0F0;
        wr(5'h00, 32'hFF00_00FF);
        #1;
        chk("R3 pad_out", pad_out, (32'hFF00_00FF & 32'h1234_5678) | (~32'hFF00_00FF & 32'hA5A5_1234));
        chk("R3 pad_oe", pad_oe, (32'hFF00_00FF & 32'hF0F0_F0F0) | (~32'hFF00_00FF & 32'h0000_FFFF));
        wr(5'h00, 32'h0);
    endtask

    task automatic t_sync;
        logic [31:0] v;
        // level = 0 on no pin... keep levels all ones, pad values 0 except test; clear after
        reg_addr = 5'h08;
        @(negedge clk);
        pad_in = 32'h0000_0040;
        cyc(1);
        rd(5'h08, v); chk("R4 after one edge", v, 32'h0);
        cyc(1);
        rd(5'h08, v); chk("R4 after two edges", v, 32'h0000_0040);
        chk("R4 alt_in", alt_in, 32'h0000_0040);
        pad_in = 32'h0;
        cyc(3);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk("R6 cleared after sync test", v, 32'h0);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        @(negedge clk); pad_in = 32'h0000_0008;
        cyc(3);
        rd(5'h10, v); chk("R5 status set", v, 32'h0000_0008);
        chk("R8 irq raised", {31'd0, irq}, 32'h1);
        pad_in = 32'h0;
        cyc(4);
        rd(5'h10, v); chk("R5 status sticky", v, 32'h0000_0008);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, v); chk("R6 write one no effect", v, 32'h0000_0008);
        wr(5'h10, 32'hFFFF_FFF7);
        rd(5'h10, v); chk("R6 write zero clears", v, 32'h0);
        chk("R8 irq dropped", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        @(negedge clk); pad_in = 32'h0000_0020;
        cyc(3);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk("R6 set wins over clear", v, 32'h0000_0020);
        pad_in = 32'h0;
        cyc(3);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk("R6 clear after release", v, 32'h0);
    endtask

    task automatic t_level_zero;
        logic [31:0] v;
        wr(5'h0C, 32'hFFFF_FF7F);
        cyc(1);
        rd(5'h10, v); chk("R5 level zero match", v, 32'h0000_0080);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk("R6 clear level test", v, 32'h0);
    endtask

    task automatic t_alt_noset_nmi;
        logic [31:0] v;
        wr(5'h00, 32'h0000_0200);
        wr(5'h0C, 32'hFFFF_FDFF);
        cyc(4);
        rd(5'h10, v); chk("R7 alt pin no status", v, 32'h0);
        wr(5'h14, 32'h0000_0200);
        rd(5'h14, v); chk("R9 nmien readback", v, 32'h0000_0200);
        wr(5'h00, 32'h0);
        cyc(1);
        rd(5'h10, v); chk("R7 gpio pin sets", v, 32'h0000_0200);
        chk("R8 nmi only", {30'd0, irq, nmi}, 32'h1);
        @(negedge clk); pad_in = 32'h0000_0008;
        cyc(3);
        chk("R8 irq and nmi", {30'd0, irq, nmi}, 32'h3);
        pad_in = 32'h0;
        wr(5'h0C, 32'hFFFF_FFFF);
        cyc(3);
        wr(5'h10, 32'h0);
        chk("R8 both clear", {30'd0, irq, nmi}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(5'h00, 32'h0F0F_0000);
        wr(5'h04, 32'h1357_9BDF);
        wr(5'h18, 32'hDEAD_BEEF);
        wr(5'h1C, 32'hDEAD_BEEF);
        wr(5'h01, 32'hDEAD_BEEF);
        rd(5'h00, v); chk("R9 func readback", v, 32'h0F0F_0000);
        rd(5'h04, v); chk("R9 dir readback", v, 32'h1357_9BDF);
        rd(5'h0C, v); chk("R9 level readback", v, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R9 nmien kept", v, 32'h0000_0200);
        rd(5'h18, v); chk("R9 unmapped read", v, 32'h0);
        rd(5'h01, v); chk("R9 misaligned read", v, 32'h0);
        #1 chk("R2 data kept", pad_out & ~32'h0F0F_0000, 32'hA5A5_1234 & ~32'h0F0F_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset;
        t_gpio_out;
        t_alt_mux;
        t_sync;
        t_sticky;
        t_set_wins;
        t_level_zero;
        t_alt_noset_nmi;
        t_map;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule